// File: doc/BRIEF.md
# Write-Enable Latch and Page-Write Engine

This block sits behind the command decoder of a serial EEPROM model and owns the write path. The decoder gives it one-cycle events: an instruction byte has arrived (arm, disarm or write), an address byte, a data byte, and the end of a chip-select frame. With the end of a frame comes a flag that says whether the frame stopped exactly on a byte boundary. From these events the block keeps the write-enable latch and collects up to one page of data in a 16-byte staging buffer. It then decides whether the write is accepted.

An accepted write starts a timed programming cycle of `TWC` clock cycles. During that cycle the busy flag is high. In the first `PAGE_BYTES` cycles of the programming cycle, the block copies each staged slot to a 256x8 array write port. It copies only the slots that were actually loaded. When the programming cycle ends, busy and the latch drop on the same clock edge. `TWC` must be at least `PAGE_BYTES`.

Top module: `wel_page_writer`

## Requirements
- R1: After reset the latch output `wel_o`, the busy output `wip_o` and the array strobe `mem_we_o` are all 0.
- R2: The latch is set only by a frame whose first instruction is arm (`cmd_arm_i`) and that carries no further byte event. The frame must also end with `cs_rise_i` while `at_byte_bnd_i` is 1. If the arm frame ends off a boundary, or if it carries extra bytes, the latch is unchanged.
- R3: A frame whose only byte is disarm (`cmd_disarm_i`) and that ends on a byte boundary clears the latch.
- R4: A write frame commits only when all of these hold: the frame has a write instruction, then an address, then at least one data byte; it ends on a byte boundary; and the latch is 1 at that moment. In every other case no array write happens and `wip_o` stays 0.
- R5: If an arm instruction and a write instruction share one frame, nothing is written and the latch stays 0.
- R6: The page base is address bits [7:4]. The data bytes land at consecutive low-nibble positions starting at the address byte's bits [3:0]. After position 15 the position wraps to 0 of the same page, and a later byte replaces an earlier one at the same position.
- R7: During a programming cycle, exactly the loaded positions of the page are written, each one once. No other array location changes.
- R8: `wip_o` rises on the clock edge that samples the committing `cs_rise_i` and stays high for exactly `TWC` cycles.
- R9: The latch clears on the same edge on which `wip_o` falls.
- R10: An arm, disarm or write frame that begins while `wip_o` is 1 has no effect on the latch, on the staged data or on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_arm_i | input | 1 | Pulse: an arm (write-enable) instruction byte is complete |
| cmd_disarm_i | input | 1 | Pulse: a disarm (write-disable) instruction byte is complete |
| cmd_write_i | input | 1 | Pulse: a write instruction byte is complete |
| addr_vld_i | input | 1 | Pulse: an address byte is complete |
| addr_i | input | ADDR_W | The address byte |
| data_vld_i | input | 1 | Pulse: a data byte is complete |
| data_i | input | DATA_W | The data byte |
| cs_rise_i | input | 1 | Pulse: chip select went inactive, the frame ends |
| at_byte_bnd_i | input | 1 | Qualifies `cs_rise_i`: 1 when no partial byte is pending |
| wel_o | output | 1 | Write-enable latch |
| wip_o | output | 1 | Programming cycle in progress |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The bench goes after these cases:
- A run of 20 bytes that starts at offset 0xC. Its last four bytes must overwrite the start of the run in the same page. A design that carried into the next page would modify 0x40 and above.
- An arm followed by a write in the same frame. A design that set the latch at the instruction byte instead of at the frame end would program the array here.
- Frames that end off a byte boundary, and a write frame with an address but no data. Both must leave the array alone and keep the busy flag low.
- Arm, disarm and write frames issued during a programming cycle. A design that honoured them would leave the latch set after the cycle, or would corrupt the bytes being copied. The bench also counts array strobes, so a design that copied unloaded slots shows up as extra writes.

// File: rtl/wpw_pkg.sv
`timescale 1ns/1ps
package wpw_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_ARM,
    FR_DISARM,
    FR_WRITE,
    FR_IGNORE
  } frame_kind_e;

  // next position inside a page, wrapping back to its first slot
  function automatic int unsigned wrap_next(int unsigned pos, int unsigned page);
    return (pos + 1) % page;
  endfunction

  // the copy phase occupies the first 'page' cycles of the programming cycle
  function automatic logic in_copy_window(int unsigned cnt, int unsigned page);
    return cnt < page;
  endfunction

endpackage

// File: rtl/wpw_frame_tracker.sv
`timescale 1ns/1ps
module wpw_frame_tracker
  import wpw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wip_i,
  input  logic wel_i,
  input  logic has_data_i,
  input  logic cmd_arm_i,
  input  logic cmd_disarm_i,
  input  logic cmd_write_i,
  input  logic addr_vld_i,
  input  logic data_vld_i,
  input  logic cs_rise_i,
  input  logic at_byte_bnd_i,
  output logic ld_addr_o,
  output logic ld_data_o,
  output logic wel_set_o,
  output logic wel_clr_o,
  output logic commit_o
);

  frame_kind_e kind_q;
  logic        spoil_q;
  logic        addr_seen_q;
  logic        any_cmd;
  logic        any_byte;
  logic        clean_end;

  assign any_cmd   = cmd_arm_i | cmd_disarm_i | cmd_write_i;
  assign any_byte  = any_cmd | addr_vld_i | data_vld_i;
  assign clean_end = cs_rise_i & at_byte_bnd_i & ~wip_i;

  assign ld_addr_o = (kind_q == FR_WRITE) & addr_vld_i & ~addr_seen_q;
  assign ld_data_o = (kind_q == FR_WRITE) & data_vld_i & addr_seen_q;
  assign wel_set_o = clean_end & (kind_q == FR_ARM) & ~spoil_q;
  assign wel_clr_o = clean_end & (kind_q == FR_DISARM) & ~spoil_q;
  assign commit_o  = clean_end & (kind_q == FR_WRITE) & addr_seen_q & has_data_i & wel_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q      <= FR_IDLE;
      spoil_q     <= 1'b0;
      addr_seen_q <= 1'b0;
    end else if (cs_rise_i) begin
      kind_q      <= FR_IDLE;
      spoil_q     <= 1'b0;
      addr_seen_q <= 1'b0;
    end else begin
      if (kind_q == FR_IDLE && any_cmd) begin
        if (wip_i)             kind_q <= FR_IGNORE;
        else if (cmd_arm_i)    kind_q <= FR_ARM;
        else if (cmd_disarm_i) kind_q <= FR_DISARM;
        else                   kind_q <= FR_WRITE;
      end else if ((kind_q == FR_ARM || kind_q == FR_DISARM) && any_byte) begin
        spoil_q <= 1'b1;
      end
      if (ld_addr_o) addr_seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/wpw_page_buffer.sv
`timescale 1ns/1ps
module wpw_page_buffer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ld_addr_i,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic                                  ld_data_i,
  input  logic [DATA_W-1:0]                     data_i,
  input  logic [$clog2(PAGE_BYTES)-1:0]         rd_slot_i,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  base_o,
  output logic                                  has_data_o,
  output logic                                  rd_loaded_o,
  output logic [DATA_W-1:0]                     rd_data_o
);

  localparam int PTR_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - PTR_W;

  logic [PTR_W-1:0]             ptr_q;
  logic [BASE_W-1:0]            base_q;
  logic [PAGE_BYTES-1:0]        mask_w;
  logic [PAGE_BYTES*DATA_W-1:0] data_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (ld_addr_i) begin
      ptr_q  <= addr_i[PTR_W-1:0];
      base_q <= addr_i[ADDR_W-1:PTR_W];
    end else if (ld_data_i) begin
      ptr_q  <= PTR_W'(wpw_pkg::wrap_next(int'(ptr_q), PAGE_BYTES));
    end
  end

  for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              used_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        used_q <= 1'b0;
      end else if (ld_addr_i) begin
        used_q <= 1'b0;
      end else if (ld_data_i && ptr_q == PTR_W'(s)) begin
        byte_q <= data_i;
        used_q <= 1'b1;
      end
    end
    assign mask_w[s]                    = used_q;
    assign data_w[s*DATA_W +: DATA_W]   = byte_q;
  end

  assign base_o      = base_q;
  assign has_data_o  = |mask_w;
  assign rd_loaded_o = mask_w[rd_slot_i];
  assign rd_data_o   = data_w[rd_slot_i*DATA_W +: DATA_W];

endmodule

// File: rtl/wpw_cycle_timer.sv
`timescale 1ns/1ps
module wpw_cycle_timer #(
  parameter int TWC        = 32,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  output logic                          wip_o,
  output logic                          copy_o,
  output logic [$clog2(PAGE_BYTES)-1:0] slot_o,
  output logic                          done_o
);

  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(TWC + PAGE_BYTES + 1);

  logic             wip_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = wip_q & (cnt_q == CNT_W'(TWC - 1));
  assign copy_o = wip_q & wpw_pkg::in_copy_window(int'(cnt_q), PAGE_BYTES);
  assign slot_o = cnt_q[PTR_W-1:0];
  assign wip_o  = wip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !wip_q) begin
      wip_q <= 1'b1;
      cnt_q <= '0;
    end else if (wip_q) begin
      if (done_o) wip_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wel_page_writer.sv
`timescale 1ns/1ps
module wel_page_writer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int TWC        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_arm_i,
  input  logic              cmd_disarm_i,
  input  logic              cmd_write_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cs_rise_i,
  input  logic              at_byte_bnd_i,
  output logic              wel_o,
  output logic              wip_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  localparam int PTR_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - PTR_W;

  // named internal events
  logic              ev_ld_addr;
  logic              ev_ld_data;
  logic              ev_wel_set;
  logic              ev_wel_clr;
  logic              ev_commit;
  logic              ev_cyc_done;
  logic              copy_en;
  logic              wip;
  logic              has_data;
  logic              slot_loaded;
  logic [PTR_W-1:0]  slot;
  logic [BASE_W-1:0] base;
  logic [DATA_W-1:0] slot_data;
  logic              wel_q;

  wpw_frame_tracker u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .wip_i         (wip),
    .wel_i         (wel_q),
    .has_data_i    (has_data),
    .cmd_arm_i     (cmd_arm_i),
    .cmd_disarm_i  (cmd_disarm_i),
    .cmd_write_i   (cmd_write_i),
    .addr_vld_i    (addr_vld_i),
    .data_vld_i    (data_vld_i),
    .cs_rise_i     (cs_rise_i),
    .at_byte_bnd_i (at_byte_bnd_i),
    .ld_addr_o     (ev_ld_addr),
    .ld_data_o     (ev_ld_data),
    .wel_set_o     (ev_wel_set),
    .wel_clr_o     (ev_wel_clr),
    .commit_o      (ev_commit)
  );

  wpw_page_buffer #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_addr_i   (ev_ld_addr),
    .addr_i      (addr_i),
    .ld_data_i   (ev_ld_data),
    .data_i      (data_i),
    .rd_slot_i   (slot),
    .base_o      (base),
    .has_data_o  (has_data),
    .rd_loaded_o (slot_loaded),
    .rd_data_o   (slot_data)
  );

  wpw_cycle_timer #(
    .TWC        (TWC),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ev_commit),
    .wip_o   (wip),
    .copy_o  (copy_en),
    .slot_o  (slot),
    .done_o  (ev_cyc_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wel_q <= 1'b0;
    else if (ev_cyc_done) wel_q <= 1'b0;
    else if (ev_wel_set)  wel_q <= 1'b1;
    else if (ev_wel_clr)  wel_q <= 1'b0;
  end

  assign wel_o       = wel_q;
  assign wip_o       = wip;
  assign mem_we_o    = copy_en & slot_loaded;
  assign mem_addr_o  = {base, slot};
  assign mem_wdata_o = slot_data;

endmodule

// File: rtl/wpw_checker.sv
`timescale 1ns/1ps
module wpw_checker #(
  parameter int TWC = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cs_rise_i,
  input logic at_byte_bnd_i,
  input logic wel_o,
  input logic wip_o,
  input logic mem_we_o
);

  int run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= 0;
    else if (wip_o) run_q <= run_q + 1;
    else            run_q <= 0;
  end

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> wip_o); // R7

  AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> $past(wel_o)); // R4

  AST_START_ON_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_o) |-> $past(cs_rise_i && at_byte_bnd_i)); // R8

  AST_CYCLE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_o) |-> (run_q == TWC)); // R8

  AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_o) |-> !wel_o); // R9

  AST_LATCH_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_o && $past(wip_o)) |-> wel_o); // R10

endmodule

bind wel_page_writer wpw_checker #(.TWC(TWC)) u_wpw_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_rise_i     (cs_rise_i),
  .at_byte_bnd_i (at_byte_bnd_i),
  .wel_o         (wel_o),
  .wip_o         (wip_o),
  .mem_we_o      (mem_we_o)
);

// File: tb/wel_page_writer_bench.sv
`timescale 1ns/1ps
module wel_page_writer_bench;

  localparam int TWC  = 32;
  localparam int PAGE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_arm, cmd_disarm, cmd_write, addr_vld, data_vld, cs_rise, at_bnd;
  logic [7:0] addr, data;
  logic       wel, wip, mem_we;
  logic [7:0] mem_addr, mem_wdata;

  int         total = 0;
  int         bad   = 0;
  int         wr_cnt = 0;
  int         w0 = 0;
  bit         exp_wel = 0;
  logic [7:0] img   [256];
  logic [7:0] exp_m [256];

  always #2.5 clk = ~clk;

  wel_page_writer #(.TWC(TWC)) u_wel_page_writer (
    .clk(clk), .rst_n(rst_n),
    .cmd_arm_i(cmd_arm), .cmd_disarm_i(cmd_disarm), .cmd_write_i(cmd_write),
    .addr_vld_i(addr_vld), .addr_i(addr), .data_vld_i(data_vld), .data_i(data),
    .cs_rise_i(cs_rise), .at_byte_bnd_i(at_bnd),
    .wel_o(wel), .wip_o(wip), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  // the array behind the write port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) img[i] <= 8'h00;
    end else if (mem_we) begin
      img[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [7:0] page_pos(logic [7:0] a, int i);
    logic [3:0] lo;
    lo = 4'((int'(a[3:0]) + i) % PAGE);
    return {a[7:4], lo};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_mem(string req);
    int mism = 0;
    for (int i = 0; i < 256; i++) if (img[i] !== exp_m[i]) mism++;
    chk(mism == 0, req, "array mismatches", mism, 0);
  endtask

  task automatic idle_all();
    cmd_arm = 0; cmd_disarm = 0; cmd_write = 0; addr_vld = 0;
    data_vld = 0; cs_rise = 0; at_bnd = 0;
  endtask

  task automatic send_cmd(int c);
    @(negedge clk);
    cmd_arm = (c == 0); cmd_disarm = (c == 1); cmd_write = (c == 2);
    @(negedge clk); idle_all();
  endtask

  task automatic send_addr(logic [7:0] a);
    @(negedge clk); addr_vld = 1; addr = a;
    @(negedge clk); idle_all();
  endtask

  task automatic send_data(logic [7:0] d);
    @(negedge clk); data_vld = 1; data = d;
    @(negedge clk); idle_all();
  endtask

  task automatic end_frame(bit bnd);
    @(negedge clk); cs_rise = 1; at_bnd = bnd;
    @(negedge clk); idle_all();
  endtask

  task automatic do_arm(bit bnd, int extra);
    send_cmd(0);
    for (int i = 0; i < extra; i++) send_data(8'($urandom));
    end_frame(bnd);
    if (bnd && extra == 0) exp_wel = 1;
    chk(wel == exp_wel, "R2", "latch after arm frame", wel, exp_wel);
  endtask

  task automatic do_disarm(bit bnd);
    send_cmd(1);
    end_frame(bnd);
    if (bnd) exp_wel = 0;
    chk(wel == exp_wel, "R3", "latch after disarm frame", wel, exp_wel);
  endtask

  // sends a write frame; returns whether a commit is expected and the loaded count
  task automatic do_write(logic [7:0] a, int n, bit bnd, output bit comm, output int loaded);
    logic [7:0] pend [PAGE];
    bit         used [PAGE];
    for (int i = 0; i < PAGE; i++) used[i] = 0;
    w0 = wr_cnt;
    send_cmd(2);
    send_addr(a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = 8'($urandom);
      logic [7:0] p = page_pos(a, i);
      send_data(d);
      pend[p[3:0]] = d;
      used[p[3:0]] = 1;
    end
    comm = exp_wel && bnd && (n > 0);
    end_frame(bnd);
    loaded = 0;
    for (int i = 0; i < PAGE; i++) if (used[i]) loaded++;
    if (comm)
      for (int i = 0; i < PAGE; i++) if (used[i]) exp_m[{a[7:4], 4'(i)}] = pend[i];
  endtask

  task automatic finish_write(bit comm, int loaded, bit measure);
    if (comm) begin
      int len = 0;
      while (wip) begin len++; @(negedge clk); end
      if (measure) chk(len == TWC, "R8", "busy length", len, TWC);
      exp_wel = 0;
      chk(wel == 0, "R9", "latch after cycle", wel, 0);
      chk(wr_cnt - w0 == loaded, "R7", "array strobes", wr_cnt - w0, loaded);
      cmp_mem("R6");
    end else begin
      repeat (3) @(negedge clk);
      chk(wip == 0, "R4", "no cycle started", wip, 0);
      chk(wr_cnt - w0 == 0, "R4", "no array strobe", wr_cnt - w0, 0);
      cmp_mem("R4");
      chk(wel == exp_wel, "R4", "latch unchanged", wel, exp_wel);
    end
  endtask

  task automatic run_write(logic [7:0] a, int n, bit bnd);
    bit c; int ld;
    do_write(a, n, bnd, c, ld);
    finish_write(c, ld, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit c; int ld;
    void'($urandom(32'h5EED));
    idle_all(); addr = 0; data = 0;
    for (int i = 0; i < 256; i++) exp_m[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(wel == 0, "R1", "latch after reset", wel, 0);
    chk(wip == 0, "R1", "busy after reset", wip, 0);
    chk(mem_we == 0, "R1", "strobe after reset", mem_we, 0);

    // R4: write with latch clear
    run_write(8'h10, 3, 1);
    // R2: arm frame ending off-boundary, and with a trailing byte
    do_arm(0, 0);
    do_arm(1, 1);
    // R5: arm and write in one frame
    w0 = wr_cnt;
    send_cmd(0); send_cmd(2); send_addr(8'h20); send_data(8'hAA); send_data(8'h55);
    end_frame(1);
    chk(wel == 0, "R5", "latch after combined frame", wel, 0);
    finish_write(0, 0, 0);
    // R2 then R3
    do_arm(1, 0);
    do_disarm(1);
    // R6: wrap inside the page, 20 bytes from offset 0xC
    do_arm(1, 0);
    run_write(8'h3C, 20, 1);
    // R4: off-boundary end and zero-data frame keep the latch and array
    do_arm(1, 0);
    run_write(8'h7E, 3, 0);
    run_write(8'h80, 0, 1);
    // R10: frames issued while busy
    do_write(8'h50, 5, 1, c, ld);
    chk(wip == 1, "R8", "busy after commit", wip, 1);
    send_cmd(1); end_frame(1);
    chk(wel == 1, "R10", "disarm ignored while busy", wel, 1);
    send_cmd(0); end_frame(1);
    send_cmd(2); send_addr(8'h90); send_data(8'h11); send_data(8'h22); send_data(8'h33);
    end_frame(1);
    chk(wip == 1, "R10", "still busy", wip, 1);
    finish_write(c, ld, 0);
    chk(wel == 0, "R10", "arm during busy left no latch", wel, 0);

    // constrained random traffic
    for (int k = 0; k < 40; k++) begin
      int r = int'($urandom % 10);
      if (r < 3)       do_arm(($urandom % 5) != 0, (($urandom % 6) == 0) ? 1 : 0);
      else if (r == 3) do_disarm(($urandom % 4) != 0);
      else             run_write(8'($urandom), int'($urandom % 21), ($urandom % 8) != 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule